// File: doc/BRIEF.md
# Pulsed-Handshake Parallel Byte Receiver

This block receives bytes from a sender over a strobe/acknowledge parallel port of the kind used by line printers. The sender places a byte on the data lines and pulses its strobe; the receiver passes the strobe through a two-flop synchronizer and latches the byte on the rising edge. It then answers with a BUSY level and an acknowledge pulse. Programmable timers set how long the acknowledge lasts and the point at which BUSY drops.

On the host side the byte is offered through a valid/ready pair. A one-byte holding register sits between the port and the host. If a new strobe arrives while the previous byte is still unread, the new byte is neither latched nor acknowledged until the host takes the old one. Software can take direct control of the BUSY pin through a force enable and a force value. A strobe that arrives while a handshake is still running is dropped, and a sticky overrun flag records it.

Top module: `pp_byte_rx`

## Requirements
- R1: A rising edge of `stb_in`, seen after a two-flop synchronizer while the receiver is idle and the holding register is free, latches `data_in`. The byte then appears on `rd_data` with `rd_valid` high, and bytes reach the host in the order they were strobed.
- R2: With the force disabled, the automatic BUSY goes high on the same clock edge that the byte is latched, which is the same edge at which `rd_valid` rises.
- R3: `ack_out` rises exactly one clock after the latch and stays high for W clocks. W is `cfg_ack_width`, and the code 0 means 256. Each accepted byte produces exactly one pulse.
- R4: `cfg_rel_mode` selects when the automatic BUSY falls: code 0 on the edge where ACK rises, code 1 on the edge where ACK falls, and codes 2 and 3 D clocks after ACK falls. D is `cfg_rel_delay`, and the code 0 means 256.
- R5: While `cfg_busy_force_en` is 1, `busy_out` equals `cfg_busy_force_val` and the automatic BUSY is masked. Latching and ACK timing continue unchanged.
- R6: A synchronized strobe rising edge that arrives while a handshake is in progress (a byte waiting, ACK pending or high, or a post-ACK delay running) is ignored. It gives no extra ACK and no byte to the host, and it sets `overrun`, which stays set until reset.
- R7: If a strobe arrives while `rd_valid` is high and `rd_ready` is low, the receiver holds BUSY and ACK low and keeps the old byte on `rd_data`. It latches the new byte on the edge where the host takes the old one, and the normal handshake then follows.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` does not change. A byte leaves on a clock edge where both are high.
- R9: During and after reset, `ack_out`, `busy_out` (force off), `rd_valid` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_in | input | 1 | Asynchronous strobe from the sender |
| data_in | input | DATA_W | Parallel data lines from the sender |
| ack_out | output | 1 | Acknowledge pulse to the sender |
| busy_out | output | 1 | BUSY level to the sender |
| cfg_ack_width | input | TIMER_W | ACK pulse width in clocks, 0 = 256 |
| cfg_rel_delay | input | TIMER_W | Delay from ACK fall to BUSY fall for delayed modes, 0 = 256 |
| cfg_rel_mode | input | 2 | BUSY release point: 0 ACK rise, 1 ACK fall, 2/3 delayed |
| cfg_busy_force_en | input | 1 | Software takes control of BUSY |
| cfg_busy_force_val | input | 1 | BUSY level driven while forced |
| rd_data | output | DATA_W | Received byte toward the host |
| rd_valid | output | 1 | A byte is waiting for the host |
| rd_ready | input | 1 | Host accepts the byte |
| overrun | output | 1 | Sticky flag: a strobe was dropped |

## Verification
The bench builds the block with its default parameters: 8-bit data, 8-bit timing fields and a two-stage synchronizer. Because the timing fields are only 8 bits wide, the bench can reach the zero code that stands for the full 256-clock interval, both for the ACK width and for the release delay. It also uses short widths, so all four release codes, a strobe dropped during a long ACK, a strobe held back by an unread byte, and a forced-low BUSY all fit into a short run.

// File: rtl/pp_rx_pkg.sv
// Package: shared types for the pulsed-handshake parallel byte receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package pp_rx_pkg;

    // BUSY release point encodings (cfg_rel_mode)
    typedef enum logic [1:0] {
        REL_ON_ACK_RISE = 2'd0,
        REL_ON_ACK_FALL = 2'd1,
        REL_DELAYED     = 2'd2,
        REL_DELAYED_ALT = 2'd3
    } rel_mode_e;

    // Handshake controller states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_PRE  = 3'd2,
        ST_ACK  = 3'd3,
        ST_GAP  = 3'd4
    } rx_state_e;

    // True for the release codes that wait a programmed delay after ACK
    function automatic logic rel_is_delayed(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/pp_rx_sync.sv
// Module: pp_rx_sync
// Brings the asynchronous strobe into the clock domain through STAGES
// flops and flags a single-cycle pulse on each rising edge seen at the
// synchronizer output.
// Assumes: the strobe stays high for longer than one clock period.
module pp_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the strobe through the synchronizer and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], async_in};
        end
    end

    // Rising edge: newest synchronized sample high, previous one low
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/pp_rx_timer.sv
// Module: pp_rx_timer
// Down-counter for handshake intervals. A load starts an interval of
// load_val clocks (0 means 2**CNT_W). expire is high during the last
// clock of the interval, so a controller acting on it ends the interval
// exactly load_val edges after the load edge.
// Assumes: a load and an expire are never wanted in the same interval.
module pp_rx_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    localparam logic [CNT_W:0] FULL_SPAN = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE       = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W:0] cnt_q;
    logic [CNT_W:0] start_val;

    // Decode the zero code to the full span
    always_comb begin
        if (load_val == '0) begin
            start_val = FULL_SPAN;
        end else begin
            start_val = {1'b0, load_val};
        end
    end

    // Load a new interval or count the running one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= start_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expire = (cnt_q == ONE);

endmodule

// File: rtl/pp_rx_outbuf.sv
// Module: pp_rx_outbuf
// One-byte holding register toward the host with a valid/ready pair.
// can_push tells the controller a byte may be written this cycle,
// either because the register is empty or because it drains now.
// Assumes: push is only raised while can_push is high.
module pp_rx_outbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          can_push
);
    logic          valid_q;
    logic [DW-1:0] data_q;

    assign can_push = !valid_q || rd_ready;

    // Track occupancy: fill on push, empty when the host takes the byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (push) begin
            valid_q <= 1'b1;
        end else if (rd_ready) begin
            valid_q <= 1'b0;
        end
    end

    // Capture the byte from the data lines on a push
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (push) begin
            data_q <= push_data;
        end
    end

    assign rd_valid = valid_q;
    assign rd_data  = data_q;

endmodule

// File: rtl/pp_rx_ctrl.sv
// Module: pp_rx_ctrl
// Handshake sequencer. Accepts a strobe edge while idle, raises the
// automatic BUSY on the latch edge, drives ACK from the next edge for the
// programmed width, and drops BUSY at the point the release mode selects.
// Strobes arriving mid-handshake set a sticky overrun flag.
// Assumes: configuration inputs are held stable during a handshake.
module pp_rx_ctrl
    import pp_rx_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_rise,
    input  logic          can_push,
    input  logic [1:0]    rel_mode,
    input  logic [TW-1:0] ack_width,
    input  logic [TW-1:0] rel_delay,
    input  logic          tmr_expire,
    output logic          latch,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          ack_q,
    output logic          busy_q,
    output logic          overrun_q
);
    rx_state_e state_q;
    rx_state_e state_d;
    logic      ack_set;
    logic      ack_clr;
    logic      busy_clr;

    // Next state, latch request and timer loads
    always_comb begin
        state_d  = state_q;
        latch    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = ack_width;
        ack_set  = 1'b0;
        ack_clr  = 1'b0;
        busy_clr = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (strobe_rise) begin
                    if (can_push) begin
                        latch   = 1'b1;
                        state_d = ST_PRE;
                    end else begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (can_push) begin
                    latch   = 1'b1;
                    state_d = ST_PRE;
                end
            end
            ST_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = ack_width;
                ack_set  = 1'b1;
                busy_clr = (rel_mode == REL_ON_ACK_RISE);
                state_d  = ST_ACK;
            end
            ST_ACK: begin
                if (tmr_expire) begin
                    ack_clr = 1'b1;
                    if (rel_is_delayed(rel_mode)) begin
                        tmr_load = 1'b1;
                        tmr_val  = rel_delay;
                        state_d  = ST_GAP;
                    end else begin
                        busy_clr = (rel_mode == REL_ON_ACK_FALL);
                        state_d  = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expire) begin
                    busy_clr = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ACK pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else if (ack_set) begin
            ack_q <= 1'b1;
        end else if (ack_clr) begin
            ack_q <= 1'b0;
        end
    end

    // Automatic BUSY register: set on the latch edge, cleared at release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (latch) begin
            busy_q <= 1'b1;
        end else if (busy_clr) begin
            busy_q <= 1'b0;
        end
    end

    // Sticky overrun: any strobe edge outside idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
        end else if (strobe_rise && (state_q != ST_IDLE)) begin
            overrun_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pp_byte_rx.sv
// Module: pp_byte_rx (top)
// Pulsed-handshake parallel byte receiver: strobe synchronizer, handshake
// sequencer with a shared interval timer, host holding register, and the
// software BUSY override at the pin.
// Assumes: the sender keeps data_in stable from before its strobe until
// it sees ACK; configuration changes only between handshakes.
module pp_byte_rx #(
    parameter int DATA_W      = 8,
    parameter int TIMER_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stb_in,
    input  logic [DATA_W-1:0]  data_in,
    output logic               ack_out,
    output logic               busy_out,
    input  logic [TIMER_W-1:0] cfg_ack_width,
    input  logic [TIMER_W-1:0] cfg_rel_delay,
    input  logic [1:0]         cfg_rel_mode,
    input  logic               cfg_busy_force_en,
    input  logic               cfg_busy_force_val,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    input  logic               rd_ready,
    output logic               overrun
);
    logic               strobe_rise;
    logic               can_push;
    logic               latch;
    logic               tmr_load;
    logic [TIMER_W-1:0] tmr_val;
    logic               tmr_expire;
    logic               ack_q;
    logic               busy_q;
    logic               overrun_q;

    pp_rx_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(stb_in),
        .rise    (strobe_rise)
    );

    pp_rx_timer #(
        .CNT_W(TIMER_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expire  (tmr_expire)
    );

    pp_rx_outbuf #(
        .DW(DATA_W)
    ) u_outbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (latch),
        .push_data(data_in),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .can_push (can_push)
    );

    pp_rx_ctrl #(
        .TW(TIMER_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_rise(strobe_rise),
        .can_push   (can_push),
        .rel_mode   (cfg_rel_mode),
        .ack_width  (cfg_ack_width),
        .rel_delay  (cfg_rel_delay),
        .tmr_expire (tmr_expire),
        .latch      (latch),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .ack_q      (ack_q),
        .busy_q     (busy_q),
        .overrun_q  (overrun_q)
    );

    // Pin drive: software override masks the automatic BUSY
    always_comb begin
        busy_out = cfg_busy_force_en ? cfg_busy_force_val : busy_q;
    end

    assign ack_out = ack_q;
    assign overrun = overrun_q;

endmodule

// File: rtl/pp_byte_rx_chk.sv
// Module: pp_byte_rx_chk
// Port-level protocol checker for pp_byte_rx, attached with bind.
// Assumes: configuration held stable across the cycles each property spans.
module pp_byte_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_out,
    input logic              busy_out,
    input logic [1:0]        cfg_rel_mode,
    input logic              cfg_busy_force_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              overrun
);

    // R4
    rel_on_ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_out) && !cfg_busy_force_en && !$past(cfg_busy_force_en)
         && cfg_rel_mode == 2'd0 && $past(cfg_rel_mode) == 2'd0)
        |-> $fell(busy_out));

    // R4
    rel_on_ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_out) && !cfg_busy_force_en && !$past(cfg_busy_force_en)
         && cfg_rel_mode == 2'd1 && $past(cfg_rel_mode) == 2'd1)
        |-> $fell(busy_out));

    // R4
    rel_delayed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_out) && !cfg_busy_force_en && cfg_rel_mode[1])
        |-> busy_out);

    // R3
    busy_covers_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out && !cfg_busy_force_en && cfg_rel_mode != 2'd0)
        |-> busy_out);

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

bind pp_byte_rx pp_byte_rx_chk #(
    .DATA_W(DATA_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .ack_out          (ack_out),
    .busy_out         (busy_out),
    .cfg_rel_mode     (cfg_rel_mode),
    .cfg_busy_force_en(cfg_busy_force_en),
    .rd_data          (rd_data),
    .rd_valid         (rd_valid),
    .rd_ready         (rd_ready),
    .overrun          (overrun)
);

// File: tb/pp_byte_rx_test.sv
// Bench for pp_byte_rx: driver tasks push expected bytes into a queue,
// a monitor pops and compares each byte the host side hands over.
module pp_byte_rx_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb_in = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       ack_out;
    logic       busy_out;
    logic [7:0] cfg_ack_width = 8'd3;
    logic [7:0] cfg_rel_delay = 8'd1;
    logic [1:0] cfg_rel_mode = 2'd1;
    logic       cfg_busy_force_en = 1'b0;
    logic       cfg_busy_force_val = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       rd_ready = 1'b1;
    logic       overrun;

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pp_byte_rx uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .stb_in            (stb_in),
        .data_in           (data_in),
        .ack_out           (ack_out),
        .busy_out          (busy_out),
        .cfg_ack_width     (cfg_ack_width),
        .cfg_rel_delay     (cfg_rel_delay),
        .cfg_rel_mode      (cfg_rel_mode),
        .cfg_busy_force_en (cfg_busy_force_en),
        .cfg_busy_force_val(cfg_busy_force_val),
        .rd_data           (rd_data),
        .rd_valid          (rd_valid),
        .rd_ready          (rd_ready),
        .overrun           (overrun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: compare each byte taken by the host with the queue head (R1)
    always @(negedge clk) begin
        if (rst_n && rd_valid && rd_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected byte", int'(rd_data), -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R1", "byte order/value", int'(rd_data), int'(e));
            end
        end
    end

    // Driver + timing measurement of one handshake
    task automatic handshake(input logic [7:0] b, input logic [1:0] mode,
                             input logic [7:0] w, input logic [7:0] d,
                             input bit inject, input bit forced);
        int t_br = -1;
        int t_bf = -1;
        int t_vr = -1;
        int t_ar = -1;
        int t_af = -1;
        int acks = 0;
        int busy_cyc = 0;
        int weff;
        int deff;
        logic pa = 1'b0;
        logic pb = 1'b0;
        logic pv = rd_valid;
        weff = (w == 8'd0) ? 256 : int'(w);
        deff = (d == 8'd0) ? 256 : int'(d);
        cfg_rel_mode  = mode;
        cfg_ack_width = w;
        cfg_rel_delay = d;
        exp_q.push_back(b);
        data_in = b;
        @(negedge clk);
        stb_in = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (i == 3) stb_in = 1'b0;
            if (inject && t_ar >= 0 && i == t_ar + 2) begin
                data_in = ~b;
                stb_in  = 1'b1;
            end
            if (inject && t_ar >= 0 && i == t_ar + 6) stb_in = 1'b0;
            if (busy_out) busy_cyc++;
            if (busy_out && !pb && t_br < 0) t_br = i;
            if (!busy_out && pb && t_bf < 0) t_bf = i;
            if (rd_valid && !pv && t_vr < 0) t_vr = i;
            if (ack_out && !pa) begin
                acks++;
                if (t_ar < 0) t_ar = i;
            end
            if (!ack_out && pa && t_af < 0) t_af = i;
            pa = ack_out;
            pb = busy_out;
            pv = rd_valid;
            if (t_af >= 0 && !busy_out && !stb_in) break;
        end
        repeat (3) @(negedge clk);
        check(t_vr >= 0, "R1", "byte latched", t_vr, 0);
        check(t_ar == t_vr + 1, "R3", "ACK one clock after latch", t_ar, t_vr + 1);
        check(t_af - t_ar == weff, "R3", "ACK width", t_af - t_ar, weff);
        check(acks == 1, "R3", "ACK pulses", acks, 1);
        if (forced) begin
            check(busy_cyc == 0, "R5", "forced-low BUSY cycles", busy_cyc, 0);
        end else begin
            check(t_br == t_vr, "R2", "BUSY rise at latch", t_br, t_vr);
            if (mode == 2'd0)
                check(t_bf == t_ar, "R4", "release at ACK rise", t_bf, t_ar);
            else if (mode == 2'd1)
                check(t_bf == t_af, "R4", "release at ACK fall", t_bf, t_af);
            else
                check(t_bf == t_af + deff, "R4", "delayed release", t_bf, t_af + deff);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Main sequence
    initial begin
        repeat (5) @(negedge clk);
        // R9 reset state
        check(ack_out == 1'b0, "R9", "ack in reset", int'(ack_out), 0);
        check(busy_out == 1'b0, "R9", "busy in reset", int'(busy_out), 0);
        check(rd_valid == 1'b0, "R9", "valid in reset", int'(rd_valid), 0);
        check(overrun == 1'b0, "R9", "overrun in reset", int'(overrun), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy_out == 1'b0 && ack_out == 1'b0, "R9", "idle after reset",
              int'({busy_out, ack_out}), 0);

        // R4 each release code, R3 widths including the 256 code
        handshake(8'hA5, 2'd0, 8'd3, 8'd1, 1'b0, 1'b0);
        handshake(8'h3C, 2'd1, 8'd5, 8'd1, 1'b0, 1'b0);
        handshake(8'h81, 2'd2, 8'd2, 8'd7, 1'b0, 1'b0);
        handshake(8'h7E, 2'd3, 8'd1, 8'd0, 1'b0, 1'b0);
        handshake(8'h00, 2'd1, 8'd0, 8'd1, 1'b0, 1'b0);
        handshake(8'hFF, 2'd2, 8'd4, 8'd1, 1'b0, 1'b0);
        check(overrun == 1'b0, "R6", "no overrun on clean traffic", int'(overrun), 0);

        // R5 forced high while idle, then forced low through a handshake
        cfg_busy_force_en  = 1'b1;
        cfg_busy_force_val = 1'b1;
        @(negedge clk);
        check(busy_out == 1'b1, "R5", "forced-high BUSY", int'(busy_out), 1);
        cfg_busy_force_val = 1'b0;
        handshake(8'h5A, 2'd1, 8'd6, 8'd1, 1'b0, 1'b1);
        cfg_busy_force_en = 1'b0;
        @(negedge clk);
        check(busy_out == 1'b0, "R5", "auto BUSY after release", int'(busy_out), 0);

        // R7 unread byte holds back the next strobe
        rd_ready = 1'b0;
        handshake(8'h11, 2'd1, 8'd2, 8'd1, 1'b0, 1'b0);
        data_in = 8'h22;
        exp_q.push_back(8'h22);
        stb_in = 1'b1;
        repeat (4) @(negedge clk);
        stb_in = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (ack_out || busy_out) seen++;
            end
            check(seen == 0, "R7", "no ACK/BUSY while unread", seen, 0);
        end
        check(rd_data == 8'h11 && rd_valid, "R8", "old byte held", int'(rd_data), 8'h11);
        check(overrun == 1'b0, "R7", "held strobe is not overrun", int'(overrun), 0);
        rd_ready = 1'b1;
        begin
            int got_ack = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (ack_out) got_ack = 1;
            end
            check(got_ack == 1, "R7", "ACK after host read", got_ack, 1);
        end
        check(exp_q.size() == 0, "R7", "held byte delivered", exp_q.size(), 0);

        // R6 strobe during a long ACK is dropped and flagged
        handshake(8'hC3, 2'd1, 8'd40, 8'd1, 1'b1, 1'b0);
        check(overrun == 1'b1, "R6", "overrun set", int'(overrun), 1);
        repeat (10) @(negedge clk);
        check(overrun == 1'b1, "R6", "overrun sticky", int'(overrun), 1);
        check(exp_q.size() == 0, "R6", "dropped byte not delivered", exp_q.size(), 0);
        check(rd_valid == 1'b0, "R6", "no extra byte", int'(rd_valid), 0);

        finish_run();
    end

endmodule